// File: doc/BRIEF.md
# Serial Sector-Buffer Access Engine

This block is the serial slave front end of a sector buffer. A host drives a chip select, a serial clock and a serial data line. Through them it can stream bytes out of a 522-byte buffer RAM, or fill that RAM and then ask for the buffer to be copied into a flash sector. The flash array sits outside the block. The block's only link to it is a one-cycle start strobe that carries the latched sector number.

All serial pins are oversampled by a fast system clock. Each pin passes through a synchronizer, and clock edges are found by comparing successive samples. The command decoder and the buffer RAM therefore run in one clock domain, and the RAM maps onto an inferred block RAM.

Each command has the same shape. An opcode byte comes first, then 16-bit address fields sent most significant bit first, then the data phase. The byte pointer counts upward and wraps after the last buffer location. The serial output is a data bit with a separate drive enable; the enable low stands for high impedance. A configuration input chooses whether output bits are launched on rising or on falling serial clock edges.

Top module: `sbuf_spi_engine`

## Requirements
- R1: Opcodes 71h and 73h start a buffer read. The opcode and each 16-bit field are sent MSB first. Only bits [9:0] of the byte-address field are used; bits [15:10] are clocked in and ignored.
- R2: On a read, the address is followed by 8 control clocks with SI=0. `so_oe` stays 0 throughout the opcode, the address and those control clocks.
- R3: With `rce`=1, output bits change after rising SCK edges. The first data bit is driven just after the rising edge of the last control clock.
- R4: With `rce`=0, output bits change after falling SCK edges. `so_oe` is still 0 at the end of the last control clock's high phase, and the first data bit is driven after the falling edge that follows.
- R5: Read data is sent lowest address first, each byte MSB first. The pointer advances by one after every byte.
- R6: After byte address 209h the pointer wraps to 0, for both reads and buffer loads.
- R7: Opcodes F6h and 98h take a 16-bit sector field, of which only bits [13:0] are kept, and then a 16-bit byte address. Incoming bytes overwrite the buffer from that address onward. A byte is committed to the RAM only once the byte after it has fully arrived, so the final 8 control clocks are never stored.
- R8: When CS_n rises after a buffer load whose last byte was complete (a whole number of bytes), `xfer_start` pulses for exactly one clock with `xfer_sector` set to the latched 14-bit sector.
- R9: A byte address above 209h makes the command invalid. Nothing is written, `so_oe` stays 0 and no start strobe is issued.
- R10: CS_n high aborts any command. `so_oe` falls within 3 clocks, the bit counter restarts, and a load aborted mid-byte issues no start strobe.
- R11: Any other opcode is ignored until CS_n goes high. No output is driven and no strobe is issued.
- R12: After reset `so_oe` and `xfer_start` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| rce | input | 1 | Output launch edge: 1 rising, 0 falling |
| so_o | output | 1 | Serial output data bit |
| so_oe | output | 1 | Serial output drive enable (0 = high impedance) |
| xfer_start | output | 1 | One-cycle request to copy the buffer into a sector |
| xfer_sector | output | 14 | Sector number that goes with `xfer_start` |

## Verification
The bench builds the block with its default parameters: 522 buffer bytes, a 10-bit pointer, a 14-bit sector and two synchronizer stages. A serial clock of twelve system clocks per period is used, so every launch and capture settles within one half period. With the default depth, one load covering the whole buffer reaches the 209h boundary in both directions. Loads and reads that start near the end of the buffer exercise the wrap, and address fields with the upper bits set show that those bits are ignored.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  localparam int FIELD_W = 16;

  localparam logic [7:0] OPC_RD_A = 8'h71;
  localparam logic [7:0] OPC_RD_B = 8'h73;
  localparam logic [7:0] OPC_WR_A = 8'hF6;
  localparam logic [7:0] OPC_WR_B = 8'h98;

  typedef enum logic [2:0] {
    ST_OPC,
    ST_SECT,
    ST_ADDR,
    ST_DUMMY,
    ST_RDATA,
    ST_WDATA,
    ST_DROP
  } sbuf_state_e;
endpackage

// File: rtl/sbuf_pin_sync.sv
module sbuf_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic cs_n_s,
  output logic cs_rise,
  output logic sck_rise,
  output logic sck_fall,
  output logic si_s
);
  logic [STAGES-1:0] cs_q, sck_q, si_q;
  logic              cs_prev, sck_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q     <= '1;
      sck_q    <= '0;
      si_q     <= '0;
      cs_prev  <= 1'b1;
      sck_prev <= 1'b0;
    end else begin
      cs_q[0]  <= cs_n;
      sck_q[0] <= sck;
      si_q[0]  <= si;
      cs_prev  <= cs_q[STAGES-1];
      sck_prev <= sck_q[STAGES-1];
    end
  end

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          cs_q[g]  <= 1'b1;
          sck_q[g] <= 1'b0;
          si_q[g]  <= 1'b0;
        end else begin
          cs_q[g]  <= cs_q[g-1];
          sck_q[g] <= sck_q[g-1];
          si_q[g]  <= si_q[g-1];
        end
      end
    end
  endgenerate

  assign cs_n_s   = cs_q[STAGES-1];
  assign si_s     = si_q[STAGES-1];
  assign cs_rise  = cs_q[STAGES-1] & ~cs_prev;
  assign sck_rise = sck_q[STAGES-1] & ~sck_prev;
  assign sck_fall = ~sck_q[STAGES-1] & sck_prev;
endmodule

// File: rtl/sbuf_ram.sv
module sbuf_ram #(
  parameter int DEPTH = 522,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sbuf_cmd_fsm.sv
module sbuf_cmd_fsm
  import sbuf_pkg::*;
#(
  parameter int DEPTH  = 522,
  parameter int AW     = $clog2(DEPTH),
  parameter int SECT_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_s,
  input  logic              cs_rise,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              si_s,
  input  logic              rce,
  input  logic [7:0]        ram_rdata,
  output logic              ram_we,
  output logic [AW-1:0]     ram_waddr,
  output logic [7:0]        ram_wdata,
  output logic [AW-1:0]     ram_raddr,
  output logic              so_o,
  output logic              so_oe,
  output logic              xfer_start,
  output logic [SECT_W-1:0] xfer_sector
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  sbuf_state_e       state;
  logic [2:0]        bit_cnt, out_cnt;
  logic [6:0]        in_sr;
  logic [7:0]        fhi, pend, out_sr;
  logic              fcnt, is_wr, pend_vld, primed;
  logic [AW-1:0]     ptr;
  logic [SECT_W-1:0] sect_q;

  logic [7:0]         rx_byte;
  logic               rx_done, launch, addr_ok, unused_hi;
  logic [FIELD_W-1:0] field_full;
  logic [AW-1:0]      addr_f, ptr_nxt;

  assign rx_byte    = {in_sr, si_s};
  assign rx_done    = sck_rise && (bit_cnt == 3'd7);
  assign field_full = {fhi, rx_byte};
  assign addr_f     = field_full[AW-1:0];
  assign addr_ok    = (addr_f <= LAST);
  assign unused_hi  = ^field_full[FIELD_W-1:SECT_W];
  assign launch     = rce ? sck_rise : sck_fall;
  assign ptr_nxt    = (ptr == LAST) ? '0 : ptr + 1'b1;
  assign ram_raddr  = ptr;
  assign so_o       = out_sr[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_OPC;
      bit_cnt     <= '0;
      out_cnt     <= '0;
      in_sr       <= '0;
      fhi         <= '0;
      pend        <= '0;
      out_sr      <= '0;
      fcnt        <= 1'b0;
      is_wr       <= 1'b0;
      pend_vld    <= 1'b0;
      primed      <= 1'b0;
      ptr         <= '0;
      sect_q      <= '0;
      ram_we      <= 1'b0;
      ram_waddr   <= '0;
      ram_wdata   <= '0;
      so_oe       <= 1'b0;
      xfer_start  <= 1'b0;
      xfer_sector <= '0;
    end else begin
      ram_we     <= 1'b0;
      xfer_start <= 1'b0;
      if (cs_n_s) begin
        if (cs_rise && state == ST_WDATA && pend_vld && bit_cnt == 3'd0) begin
          xfer_start  <= 1'b1;
          xfer_sector <= sect_q;
        end
        state    <= ST_OPC;
        bit_cnt  <= '0;
        fcnt     <= 1'b0;
        so_oe    <= 1'b0;
        pend_vld <= 1'b0;
        primed   <= 1'b0;
      end else begin
        if (sck_rise) begin
          bit_cnt <= bit_cnt + 1'b1;
          in_sr   <= rx_byte[6:0];
        end
        if (rx_done) begin
          case (state)
            ST_OPC: begin
              fcnt <= 1'b0;
              if (rx_byte == OPC_RD_A || rx_byte == OPC_RD_B) begin
                state <= ST_ADDR;
                is_wr <= 1'b0;
              end else if (rx_byte == OPC_WR_A || rx_byte == OPC_WR_B) begin
                state <= ST_SECT;
                is_wr <= 1'b1;
              end else begin
                state <= ST_DROP;
              end
            end
            ST_SECT: begin
              if (!fcnt) begin
                fhi  <= rx_byte;
                fcnt <= 1'b1;
              end else begin
                sect_q <= field_full[SECT_W-1:0];
                fcnt   <= 1'b0;
                state  <= ST_ADDR;
              end
            end
            ST_ADDR: begin
              if (!fcnt) begin
                fhi  <= rx_byte;
                fcnt <= 1'b1;
              end else begin
                fcnt     <= 1'b0;
                pend_vld <= 1'b0;
                if (!addr_ok) begin
                  state <= ST_DROP;
                end else begin
                  ptr   <= addr_f;
                  state <= is_wr ? ST_WDATA : ST_DUMMY;
                end
              end
            end
            ST_DUMMY: begin
              state <= ST_RDATA;
              if (rce) begin
                out_sr  <= ram_rdata;
                out_cnt <= 3'd7;
                ptr     <= ptr_nxt;
                primed  <= 1'b1;
                so_oe   <= 1'b1;
              end else begin
                primed  <= 1'b0;
              end
            end
            ST_WDATA: begin
              if (pend_vld) begin
                ram_we    <= 1'b1;
                ram_waddr <= ptr;
                ram_wdata <= pend;
                ptr       <= ptr_nxt;
              end
              pend     <= rx_byte;
              pend_vld <= 1'b1;
            end
            default: ;
          endcase
        end
        if (state == ST_RDATA && launch) begin
          if (!primed || out_cnt == 3'd0) begin
            out_sr  <= ram_rdata;
            out_cnt <= 3'd7;
            ptr     <= ptr_nxt;
            primed  <= 1'b1;
            so_oe   <= 1'b1;
          end else begin
            out_sr  <= {out_sr[6:0], 1'b0};
            out_cnt <= out_cnt - 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sbuf_spi_engine.sv
module sbuf_spi_engine #(
  parameter int BUF_BYTES   = 522,
  parameter int SECT_W      = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              rce,
  output logic              so_o,
  output logic              so_oe,
  output logic              xfer_start,
  output logic [SECT_W-1:0] xfer_sector
);
  localparam int AW = $clog2(BUF_BYTES);

  logic          cs_n_s, cs_rise, sck_rise, sck_fall, si_s;
  logic          ram_we;
  logic [AW-1:0] ram_waddr, ram_raddr;
  logic [7:0]    ram_wdata, ram_rdata;

  sbuf_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si),
    .cs_n_s(cs_n_s), .cs_rise(cs_rise), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .si_s(si_s)
  );

  sbuf_cmd_fsm #(.DEPTH(BUF_BYTES), .AW(AW), .SECT_W(SECT_W)) u_fsm (
    .clk(clk), .rst(rst), .cs_n_s(cs_n_s), .cs_rise(cs_rise),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .si_s(si_s), .rce(rce),
    .ram_rdata(ram_rdata), .ram_we(ram_we), .ram_waddr(ram_waddr),
    .ram_wdata(ram_wdata), .ram_raddr(ram_raddr), .so_o(so_o),
    .so_oe(so_oe), .xfer_start(xfer_start), .xfer_sector(xfer_sector)
  );

  sbuf_ram #(.DEPTH(BUF_BYTES), .AW(AW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );
endmodule

// File: rtl/sbuf_spi_checker.sv
module sbuf_spi_checker #(
  parameter int DEPTH = 522,
  parameter int AW    = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_n,
  input logic          sck,
  input logic          so_o,
  input logic          so_oe,
  input logic          xfer_start,
  input logic          ram_we,
  input logic [AW-1:0] ram_waddr
);
  logic [2:0] seen;

  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else if (seen != 3'd7) seen <= seen + 1'b1;
  end

  // R10: four samples of CS_n high leave the output undriven
  p_oe_off_r10: assert property (@(posedge clk) disable iff (rst)
    (seen == 3'd7 && cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3))
      |-> !so_oe);

  // R8: the start request lasts one clock
  p_start_single_r8: assert property (@(posedge clk) disable iff (rst)
    xfer_start |=> !xfer_start);

  // R8: the start request only follows CS_n going high
  p_start_cs_high_r8: assert property (@(posedge clk) disable iff (rst)
    xfer_start |-> cs_n);

  // R7: buffer writes stay inside the buffer
  p_waddr_range_r7: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (ram_waddr <= AW'(DEPTH - 1)));

  // R3: the output moves only in response to a serial pin edge
  p_so_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (seen == 3'd7 && $stable(sck) && $past(sck) == $past(sck, 2) &&
     $past(sck, 2) == $past(sck, 3) && $past(sck, 3) == $past(sck, 4) &&
     $stable(cs_n) && $past(cs_n) == $past(cs_n, 2) &&
     $past(cs_n, 2) == $past(cs_n, 3) && $past(cs_n, 3) == $past(cs_n, 4))
      |-> ($stable(so_o) && $stable(so_oe)));
endmodule

bind sbuf_spi_engine sbuf_spi_checker #(.DEPTH(BUF_BYTES), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .so_o(so_o),
  .so_oe(so_oe), .xfer_start(xfer_start), .ram_we(ram_we),
  .ram_waddr(ram_waddr)
);

// File: tb/sbuf_spi_engine_tb_top.sv
module sbuf_spi_engine_tb_top;
  localparam int DEPTH = 522;
  localparam int HALF  = 6;

  logic        clk = 1'b0, rst = 1'b1;
  logic        cs_n = 1'b1, sck = 1'b0, si = 1'b0, rce = 1'b0;
  logic        so_o, so_oe, xfer_start;
  logic [13:0] xfer_sector;

  sbuf_spi_engine dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .rce(rce),
    .so_o(so_o), .so_oe(so_oe), .xfer_start(xfer_start),
    .xfer_sector(xfer_sector)
  );

  always #4 clk = ~clk;

  int          checks = 0, failures = 0, starts = 0;
  logic [13:0] last_sect = '0;
  logic [7:0]  model [DEPTH];
  logic [7:0]  exp_q [$];
  logic [7:0]  obs_q [$];
  string       cur_tag = "R5";

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] gen(input int seed, input int i);
    return 8'(seed * 31 + i * 7 + 3);
  endfunction

  function automatic int nxt(input int p);
    return (p == DEPTH - 1) ? 0 : p + 1;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bit(input bit b);
    si = b; tick(HALF); sck = 1'b1; tick(HALF); sck = 1'b0;
  endtask

  task automatic spi_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) spi_bit(b[i]);
  endtask

  task automatic end_cmd();
    si = 1'b0; tick(HALF); cs_n = 1'b1; tick(24);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0 && obs_q.size() > 0) begin
      logic [7:0] e, o;
      e = exp_q.pop_front();
      o = obs_q.pop_front();
      chk(o === e, cur_tag, o, e);
    end
  end

  always @(negedge clk) begin
    if (xfer_start) begin
      starts++;
      last_sect = xfer_sector;
    end
  end

  task automatic wr_cmd(input logic [7:0] opc, input logic [15:0] sect,
                        input logic [15:0] addr, input int n, input int seed,
                        input bit valid);
    int s0 = starts;
    int p;
    cs_n = 1'b0; tick(HALF);
    spi_byte(opc);
    spi_byte(sect[15:8]); spi_byte(sect[7:0]);
    spi_byte(addr[15:8]); spi_byte(addr[7:0]);
    for (int i = 0; i < n; i++) spi_byte(gen(seed, i));
    spi_byte(8'h00);
    end_cmd();
    if (valid) begin
      p = int'(addr[9:0]);
      for (int i = 0; i < n; i++) begin
        model[p] = gen(seed, i);
        p = nxt(p);
      end
      chk(starts == s0 + 1, "R8 one start strobe", starts - s0, 1);
      chk(last_sect == sect[13:0], "R7 sector bits kept", last_sect, sect[13:0]);
    end else begin
      chk(starts == s0, "R9 no strobe on bad address", starts - s0, 0);
    end
  endtask

  task automatic rd_cmd(input logic [7:0] opc, input logic [15:0] addr,
                        input int n, input bit rce_v, input bit valid,
                        input string tag);
    bit         oe_any = 1'b0, oe_miss = 1'b0;
    logic [7:0] acc = '0;
    int         nb = 0, p;
    cur_tag = tag;
    rce = rce_v;
    if (valid) begin
      p = int'(addr[9:0]);
      for (int i = 0; i < n; i++) begin
        exp_q.push_back(model[p]);
        p = nxt(p);
      end
    end
    cs_n = 1'b0; tick(HALF);
    spi_byte(opc);
    spi_byte(addr[15:8]); spi_byte(addr[7:0]);
    for (int i = 0; i < 7; i++) spi_bit(1'b0);
    si = 1'b0; tick(HALF);
    chk(so_oe == 1'b0, "R2 undriven through control clocks", so_oe, 0);
    sck = 1'b1; tick(HALF);
    if (rce_v) begin
      oe_any |= so_oe; oe_miss |= !so_oe; acc = {acc[6:0], so_o}; nb++;
    end else begin
      chk(so_oe == 1'b0, "R4 undriven until next falling edge", so_oe, 0);
    end
    sck = 1'b0;
    for (int i = 0; i < 8 * n; i++) begin
      tick(HALF);
      if (!rce_v) begin
        oe_any |= so_oe; oe_miss |= !so_oe; acc = {acc[6:0], so_o}; nb++;
      end
      if (nb == 8) begin
        if (valid) obs_q.push_back(acc);
        nb = 0;
      end
      sck = 1'b1; tick(HALF);
      if (rce_v && i < 8 * n - 1) begin
        oe_any |= so_oe; oe_miss |= !so_oe; acc = {acc[6:0], so_o}; nb++;
      end
      if (nb == 8) begin
        if (valid) obs_q.push_back(acc);
        nb = 0;
      end
      sck = 1'b0;
    end
    end_cmd();
    if (valid) chk(!oe_miss, rce_v ? "R3 driven on rising launch" : "R4 driven on falling launch", oe_miss, 0);
    else       chk(!oe_any, "R9 no output on bad address", oe_any, 0);
    chk(so_oe == 1'b0, "R10 undriven after CS high", so_oe, 0);
    tick(4);
  endtask

  initial begin
    repeat (190000) @(negedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int s0;
    bit oe_any;
    tick(10);
    rst = 1'b0;
    tick(5);
    chk(so_oe == 1'b0, "R12 reset so_oe", so_oe, 0);
    chk(xfer_start == 1'b0, "R12 reset xfer_start", xfer_start, 0);

    // R7: fill whole buffer, upper sector bits set
    wr_cmd(8'hF6, 16'hC123, 16'h0000, DEPTH, 1, 1'b1);
    rd_cmd(8'h71, 16'h0000, 6, 1'b1, 1'b1, "R3 R5 read rising launch");
    rd_cmd(8'h73, 16'hFD00, 5, 1'b0, 1'b1, "R1 R4 upper address bits ignored");
    rd_cmd(8'h71, 16'h0200, 10, 1'b1, 1'b1, "R6 read across 209h from fill");

    // R6: load wrapping past 209h
    wr_cmd(8'h98, 16'h8ABC, 16'h0205, 8, 2, 1'b1);
    rd_cmd(8'h71, 16'h0204, 10, 1'b0, 1'b1, "R6 wrap read after wrapped load");

    // R9: invalid addresses
    rd_cmd(8'h71, 16'h020A, 2, 1'b1, 1'b0, "R9 bad read");
    wr_cmd(8'hF6, 16'h0001, 16'h0300, 4, 3, 1'b0);
    rd_cmd(8'h73, 16'h0300 & 16'h0000, 4, 1'b1, 1'b1, "R9 buffer untouched");

    // R10 and R7: load aborted mid-byte
    s0 = starts;
    cs_n = 1'b0; tick(HALF);
    spi_byte(8'hF6); spi_byte(8'h00); spi_byte(8'h05);
    spi_byte(8'h00); spi_byte(8'h10);
    for (int i = 0; i < 3; i++) spi_byte(gen(4, i));
    for (int i = 0; i < 4; i++) spi_bit(1'b1);
    cs_n = 1'b1; tick(24);
    chk(starts == s0, "R10 no strobe after mid-byte abort", starts - s0, 0);
    model[16'h10] = gen(4, 0);
    model[16'h11] = gen(4, 1);
    rd_cmd(8'h71, 16'h0010, 3, 1'b0, 1'b1, "R7 R10 commit only on next byte");

    // R10: read aborted while driving
    rce = 1'b1;
    cs_n = 1'b0; tick(HALF);
    spi_byte(8'h71); spi_byte(8'h00); spi_byte(8'h20);
    spi_byte(8'h00);
    for (int i = 0; i < 3; i++) spi_bit(1'b0);
    chk(so_oe == 1'b1, "R3 driven before abort", so_oe, 1);
    cs_n = 1'b1; tick(4);
    chk(so_oe == 1'b0, "R10 abort drops drive", so_oe, 0);
    tick(20);

    // R11: unknown opcode
    s0 = starts;
    oe_any = 1'b0;
    cs_n = 1'b0; tick(HALF);
    spi_byte(8'h55); spi_byte(8'h71); spi_byte(8'h00); spi_byte(8'h00);
    for (int i = 0; i < 16; i++) begin
      spi_bit(1'b0);
      oe_any |= so_oe;
    end
    end_cmd();
    chk(!oe_any, "R11 unknown opcode drives nothing", oe_any, 0);
    chk(starts == s0, "R11 unknown opcode no strobe", starts - s0, 0);

    tick(10);
    chk(exp_q.size() == 0 && obs_q.size() == 0, "R5 every expected byte observed",
        exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule